// File: doc/BRIEF.md
# FIFO level interrupt combiner

This block merges the FIFO level events of a serial peripheral controller into one level-sensitive interrupt line. It watches the transmit and receive FIFO fill levels and the push and pop strobes with their full and empty flags. From these it derives five interrupt sources.

Two of the sources come from comparing each FIFO level with a programmable 5-bit threshold, and they follow the levels from cycle to cycle. The other three are access errors: pushing into a full FIFO, or popping from an empty one. These are latched until a write to the clear register removes them.

A mask selects which sources may raise the line. A polarity bit decides whether the line is active high or active low. Configuration arrives over a simple one-cycle write port. The raw and masked status vectors are visible as outputs.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset both thresholds, the mask, the polarity bit and every latched error are zero, so the interrupt output is low.
- R2: Status bit 4 (receive threshold) is 1 in the same cycle that `rx_level` is strictly greater than the receive threshold. A threshold of N-1 fires once N entries are present.
- R3: Status bit 0 (transmit threshold) is 1 in the same cycle that `tx_level` is at or below the transmit threshold. A threshold of 0 fires only when the level is zero.
- R4: A cycle with `tx_push` and `tx_full` both high sets status bit 1 (transmit overflow) from the next cycle on. The bit stays set until it is cleared. A push while not full sets nothing.
- R5: A cycle with `rx_push` and `rx_full` both high sets status bit 3 (receive overflow) from the next cycle on. The bit stays set until it is cleared.
- R6: A cycle with `rx_pop` and `rx_empty` both high sets status bit 2 (receive underflow) from the next cycle on. The bit stays set until it is cleared.
- R7: A write to the clear register (address 4) clears latched bits from the next cycle:
  - data bit 3 clears transmit overflow;
  - data bit 2 clears receive overflow;
  - data bit 1 clears receive underflow;
  - data bit 0 clears all three.

  Status bits 4 and 0 are not affected by this write.
- R8: When an error event and a clear of the same bit fall in the same cycle, the bit is set afterwards.
- R9: `masked_stat` equals `raw_stat` ANDed with the 5-bit mask, which uses the same bit layout as the status.
- R10: With the polarity bit at 0, `irq` is the OR of `masked_stat`. With it at 1, `irq` is the inverse of that OR. `irq` returns to its inactive level in the same cycle that no masked source remains.
- R11: The write port decodes these addresses:
  - 0: transmit threshold;
  - 1: receive threshold;
  - 2: mask;
  - 3: polarity (data bit 0).

  Threshold writes keep only data bits 4:0, and mask writes keep only bits 4:0. A write takes effect in the cycle after `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | DW | Write data |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_push | input | 1 | Transmit FIFO push strobe |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_push | input | 1 | Receive FIFO push strobe |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_pop | input | 1 | Receive FIFO pop strobe |
| rx_empty | input | 1 | Receive FIFO empty flag |
| raw_stat | output | 5 | Unmasked source status |
| masked_stat | output | 5 | Status ANDed with mask |
| irq | output | 1 | Interrupt line after polarity |

## Verification
The bench builds the block with its defaults: a 6-bit level for a 32-entry FIFO, 5-bit thresholds and 8-bit write data. This reaches a level of 32 above the largest threshold of 31, so the strict receive comparison is exercised at its top end.

The 8-bit data also carries bits above the threshold field, so the bench can show that those bits are dropped. It also drives a clear and an error in the same cycle to show which one wins.

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl #(
  parameter int LVL_W = 6,
  parameter int THR_W = 5,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_push,
  input  logic             tx_full,
  input  logic             rx_push,
  input  logic             rx_full,
  input  logic             rx_pop,
  input  logic             rx_empty,
  output logic [4:0]       raw_stat,
  output logic [4:0]       masked_stat,
  output logic             irq
);
  localparam logic [2:0] A_TXTHR = 3'd0, A_RXTHR = 3'd1, A_MASK = 3'd2,
                         A_POL = 3'd3, A_CLR = 3'd4;
  localparam int CW = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [4:0]       mask_q;
  logic             pol_q;
  logic             txovf_q, rxovf_q, rxudf_q;

  wire clr     = wr_en && (wr_addr == A_CLR);
  wire clr_all = clr && wr_data[0];
  wire ev_txovf = tx_push && tx_full;
  wire ev_rxovf = rx_push && rx_full;
  wire ev_rxudf = rx_pop && rx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr  <= '0;
      rx_thr  <= '0;
      mask_q  <= '0;
      pol_q   <= 1'b0;
      txovf_q <= 1'b0;
      rxovf_q <= 1'b0;
      rxudf_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_TXTHR) tx_thr <= wr_data[THR_W-1:0];
      if (wr_en && wr_addr == A_RXTHR) rx_thr <= wr_data[THR_W-1:0];
      if (wr_en && wr_addr == A_MASK)  mask_q <= wr_data[4:0];
      if (wr_en && wr_addr == A_POL)   pol_q  <= wr_data[0];
      txovf_q <= ev_txovf | (txovf_q & ~(clr_all | (clr & wr_data[3])));
      rxovf_q <= ev_rxovf | (rxovf_q & ~(clr_all | (clr & wr_data[2])));
      rxudf_q <= ev_rxudf | (rxudf_q & ~(clr_all | (clr & wr_data[1])));
    end
  end

  wire rx_hit = CW'(rx_level) >  CW'(rx_thr);
  wire tx_hit = CW'(tx_level) <= CW'(tx_thr);

  assign raw_stat    = {rx_hit, rxovf_q, rxudf_q, txovf_q, tx_hit};
  assign masked_stat = raw_stat & mask_q;
  assign irq         = (|masked_stat) ^ pol_q;

  AST_TXOVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full) |=> raw_stat[1]); // R4
  AST_RXOVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> raw_stat[3]); // R5
  AST_RXUDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty) |=> raw_stat[2]); // R6
  AST_RXOVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat[3] && !(wr_en && wr_addr == A_CLR && (wr_data[2] || wr_data[0])))
    |=> raw_stat[3]); // R5
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR && wr_data[0] && !tx_push && !rx_push && !rx_pop)
    |=> (raw_stat[3:1] == 3'b000)); // R7
  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_stat & ~raw_stat) == 5'b0); // R9
endmodule

// File: tb/tb_fifo_irq_ctrl.sv
module tb_fifo_irq_ctrl;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [5:0] tx_level = 0, rx_level = 0;
  logic tx_push = 0, tx_full = 0, rx_push = 0, rx_full = 0, rx_pop = 0, rx_empty = 0;
  logic [4:0] raw_stat, masked_stat;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  fifo_irq_ctrl dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .tx_level, .rx_level,
    .tx_push, .tx_full, .rx_push, .rx_full, .rx_pop, .rx_empty, .raw_stat, .masked_stat, .irq);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 0; wr_data = 0;
  endtask

  task automatic pulse(logic tp, logic tf, logic rp, logic rf, logic po, logic re);
    @(negedge clk);
    tx_push = tp; tx_full = tf; rx_push = rp; rx_full = rf; rx_pop = po; rx_empty = re;
    @(posedge clk); #1
    tx_push = 0; tx_full = 0; rx_push = 0; rx_full = 0; rx_pop = 0; rx_empty = 0;
  endtask

  task automatic t_reset;
    #2 chk("R1 raw", raw_stat, 5'b00001);
    chk("R1 masked", masked_stat, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_rx_thr;
    wr(3'd1, 8'd3);
    rx_level = 3; #1 chk("R2 at thr", raw_stat[4], 0);
    rx_level = 4; #1 chk("R2 above", raw_stat[4], 1);
    wr(3'd1, 8'd31);
    rx_level = 31; #1 chk("R2 at 31", raw_stat[4], 0);
    rx_level = 32; #1 chk("R2 level 32", raw_stat[4], 1);
    rx_level = 0;
  endtask

  task automatic t_tx_thr;
    tx_level = 0; #1 chk("R3 empty thr0", raw_stat[0], 1);
    tx_level = 1; #1 chk("R3 one thr0", raw_stat[0], 0);
    wr(3'd0, 8'd16);
    tx_level = 16; #1 chk("R3 at thr", raw_stat[0], 1);
    tx_level = 17; #1 chk("R3 above", raw_stat[0], 0);
    wr(3'd0, 8'hE3);
    tx_level = 3; #1 chk("R11 upper bits dropped", raw_stat[0], 1);
    tx_level = 4; #1 chk("R11 thr=3", raw_stat[0], 0);
  endtask

  task automatic t_errors;
    pulse(1, 0, 1, 0, 1, 0);
    chk("R4 push not full", raw_stat[3:1], 0);
    pulse(1, 1, 0, 0, 0, 0);
    chk("R4 txovf", raw_stat[3:1], 3'b001);
    pulse(0, 0, 1, 1, 0, 0);
    chk("R5 rxovf", raw_stat[3:1], 3'b101);
    pulse(0, 0, 0, 0, 1, 1);
    chk("R6 rxudf", raw_stat[3:1], 3'b111);
    repeat (3) @(posedge clk);
    #1 chk("R4 R5 R6 sticky", raw_stat[3:1], 3'b111);
  endtask

  task automatic t_clear;
    tx_level = 0; wr(3'd0, 8'd0);
    wr(3'd4, 8'h08); chk("R7 clr txovf", raw_stat, 5'b01101);
    wr(3'd4, 8'h04); chk("R7 clr rxovf", raw_stat, 5'b00101);
    wr(3'd4, 8'h02); chk("R7 clr rxudf", raw_stat, 5'b00001);
    pulse(1, 1, 1, 1, 1, 1);
    rx_level = 5; wr(3'd1, 8'd0);
    wr(3'd4, 8'h01); chk("R7 clr all keeps thr bits", raw_stat, 5'b10001);
    rx_level = 0;
  endtask

  task automatic t_set_wins;
    @(negedge clk); wr_en = 1; wr_addr = 3'd4; wr_data = 8'h0F; tx_push = 1; tx_full = 1;
    @(posedge clk); #1 wr_en = 0; wr_data = 0; tx_push = 0; tx_full = 0;
    chk("R8 set wins", raw_stat[1], 1);
    wr(3'd4, 8'h0F); chk("R8 then cleared", raw_stat[1], 0);
  endtask

  task automatic t_irq;
    tx_level = 10;
    #1 chk("R10 no src", irq, 0);
    pulse(0, 0, 0, 0, 1, 1);
    chk("R9 mask 0", masked_stat, 0);
    wr(3'd2, 8'hE4); chk("R9 mask udf", masked_stat, 5'b00100);
    chk("R10 irq high", irq, 1);
    wr(3'd3, 8'h01); chk("R10 inverted", irq, 0);
    wr(3'd4, 8'h02); chk("R10 low pol idle", irq, 1);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h11); chk("R10 idle", irq, 0);
    rx_level = 1; #1 chk("R9 rx thr masked", masked_stat, 5'b10000);
    chk("R10 level irq", irq, 1);
    rx_level = 0; #1 chk("R10 deassert", irq, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_rx_thr; t_tx_thr; t_errors; t_clear; t_set_wins; t_irq;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule